// File: doc/BRIEF.md
# Byte-Wide SPI Master/Slave Controller

This block moves one byte at a time over a four-wire serial link. It can act as the master or as the slave. As master it makes the serial clock by dividing the system clock. It drives the clock, the outbound data line and an active-low chip select, and it samples the inbound data line. As slave it takes the clock, data and select lines from outside. It passes them through synchronizers and shifts on the edges it detects.

A host sets the block up through a small register port with three addresses. Address 0 is the control byte. Address 1 is the data register: writing it loads the outbound byte, and reading it returns the last received byte. Address 2 is a status byte. The control byte selects the role, the bit order, the clock polarity and phase, and the clock rate. The block supports all four polarity/phase combinations and both bit orders.

While the block is master, a low level on the select input takes it out of the master role. Any transfer in progress is dropped and a sticky fault is raised for the host to see.

Top module: `spi_ctl`

## Requirements
- R1: After a synchronous active-low reset, these values hold: control reads 0x00, status reads 0x00, `cs_n_o`=1, `sck_o`=0 and `miso_oe`=0.
- R2: The control byte at address 0 reads back as written. Its fields are:
  - bit 7: clock double
  - bit 6: enable
  - bit 5: LSB-first
  - bit 4: master
  - bits 3:2: mode, where bit 3 is the idle clock level and bit 2 selects setup on the leading edge
  - bits 1:0: rate code
- R3: While enable is 0, writing the data register starts no transfer: `cs_n_o` stays 1 and `sck_o` does not move. While enable is 0, the slave output is never enabled.
- R4: A data write while master and enabled starts a transfer on that clock edge. The half period is H system clocks: rate codes 0, 1, 2, 3 give H = 2, 8, 32, 64, and clock double halves H. Serial clock edge k (k = 0..15) occurs H·(k+1) clocks after the write. `cs_n_o` is low from the write until edge 15.
- R5: `sck_o` rests at mode bit 3 whenever no transfer runs, and it toggles at each edge. In mode bit 2 = 0, data is sampled on the leading edges and the first bit sits on `mosi_o` from the start. In mode bit 2 = 1, the first bit appears only at the first leading edge (`mosi_o` is 0 before it), and data is sampled on the trailing edges.
- R6: With LSB-first = 0, bit 7 is sent and received first. With LSB-first = 1, bit 0 goes first.
- R7: After the eighth sampling edge, the received byte is readable at address 1 and status bit 0 (`xfer_done`) is set. Reading address 1 clears it.
- R8: When the synchronized `ss_n_i` is low while enabled as master, the master bit clears and any transfer stops. After that, `sck_o` returns to idle, `cs_n_o` returns high, and status bit 1 (`mode_fault`) is set. Reading address 2 clears the fault.
- R9: As an enabled slave with `ss_n_i` low, the block samples `mosi_i` and drives `miso_o` on the `sck_i` edges chosen by the mode. It ignores the rate code and delivers the received byte as in R7.
- R10: As a slave, `miso_oe` is 0 while `ss_n_i` is high. A rise of `ss_n_i` restarts the bit counters, so a partial byte is discarded and the next byte begins again at its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (clears flags on read) |
| reg_addr | input | 2 | 0 control, 1 data, 2 status |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| xfer_done | output | 1 | Sticky transfer-complete flag |
| mode_fault | output | 1 | Sticky master-demotion flag |
| sck_o | output | 1 | Serial clock driven as master |
| mosi_o | output | 1 | Outbound data as master |
| cs_n_o | output | 1 | Chip select as master, active low |
| sck_i | input | 1 | Serial clock received as slave |
| mosi_i | input | 1 | Inbound data as slave |
| ss_n_i | input | 1 | Select input, active low |
| miso_i | input | 1 | Inbound data as master |
| miso_o | output | 1 | Outbound data as slave |
| miso_oe | output | 1 | Output enable for `miso_o` |

## Verification
In master role, every pin result is tied to the data-write edge. Serial clock edge k lands H·(k+1) clocks later, and chip select releases at edge 15. The bench therefore computes, for every cycle after the write, the number of edges already taken and the expected `sck_o`, `cs_n_o` and `mosi_o`, and compares them on each falling clock. Slave inputs pass through two synchronizer stages and an edge detector, so they act three clocks late. The bench holds each `sck_i` level for eight clocks and reads `miso_o` just before the edge it would sample on. Flags and the mode fault are checked through register reads a few clocks after the event that sets them, which leaves room for the synchronizer delay.

// File: rtl/spi_ctl_pkg.sv
// Shared types and helpers for the SPI controller.
// Assumes an 8-bit data byte and the three-address host map below.
package spi_ctl_pkg;

    localparam int DW     = 8;   // bits per transfer
    localparam int HALF_W = 7;   // width of the half-period count

    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_DAT = 2'd1;
    localparam logic [1:0] A_STS = 2'd2;

    typedef struct packed {
        logic       dbl;        // halve the serial clock period
        logic       en;         // block enable
        logic       lsb_first;  // shift bit 0 first
        logic       mst;        // master role
        logic       cpol;       // idle level of the serial clock
        logic       cpha;       // setup on leading, sample on trailing
        logic [1:0] rate;       // divider code
    } ctl_t;

    // Half period of the master clock in system clocks.
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
        logic [HALF_W-1:0] h;
        case (rate)
            2'd0:    h = HALF_W'(2);
            2'd1:    h = HALF_W'(8);
            2'd2:    h = HALF_W'(32);
            default: h = HALF_W'(64);
        endcase
        return dbl ? (h >> 1) : h;
    endfunction

endpackage

// File: rtl/spi_ctl_sync.sv
// Multi-bit level synchronizer, one flop chain per bit.
// Assumes each input is a slow level that may be sampled bit by bit.
module spi_ctl_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the inputs through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_ctl_clkgen.sv
// Master clock divider: counts system clocks while run is high and
// flags an edge every `half` clocks. phase is the toggled clock state
// before the flagged edge (0 means the next edge is a leading one).
// Assumes half >= 1; half is not changed mid-transfer.
module spi_ctl_clkgen #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half,
    output logic          edge_stb,
    output logic          phase
);
    logic [CW-1:0] cnt;

    assign edge_stb = run && (cnt == half - CW'(1));

    // Count toward the next edge and toggle phase on it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (edge_stb) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R4
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0 && !phase));
endmodule

// File: rtl/spi_ctl_shift.sv
// Bit engine shared by both roles: holds the outbound byte, selects the
// outbound bit, assembles the inbound byte on sampling strobes.
// Assumes DW is a power of two so the bit counters wrap between bytes.
module spi_ctl_shift #(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    input  logic          lead_stb,
    input  logic          trail_stb,
    input  logic          cpha,
    input  logic          lsb_first,
    input  logic          sdi,
    output logic          sdo,
    output logic          done,
    output logic [DW-1:0] rx_nxt
);
    localparam logic [BW-1:0] LAST = BW'(DW - 1);

    logic [DW-1:0] tx, rx;
    logic [BW-1:0] bitn, sn;
    logic          drv;
    logic          sample_stb, setup_stb;

    function automatic logic [BW-1:0] pos(input logic [BW-1:0] i, input logic lsb);
        return lsb ? i : LAST - i;
    endfunction

    assign sample_stb = cpha ? trail_stb : lead_stb;
    assign setup_stb  = cpha ? lead_stb  : trail_stb;
    assign done       = sample_stb && (sn == LAST);
    assign sdo        = (cpha && !drv) ? 1'b0 : tx[pos(bitn, lsb_first)];

    // Next inbound byte including the bit sampled this cycle.
    always_comb begin
        rx_nxt = rx;
        if (sample_stb) rx_nxt[pos(sn, lsb_first)] = sdi;
    end

    // Advance the counters on setup and sample strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx   <= '0;
            rx   <= '0;
            bitn <= '0;
            sn   <= '0;
            drv  <= 1'b0;
        end else begin
            if (load) tx <= load_byte;
            if (clr || load) begin
                bitn <= '0;
                sn   <= '0;
                drv  <= 1'b0;
            end else begin
                if (setup_stb) begin
                    if (cpha && !drv) drv  <= 1'b1;
                    else              bitn <= bitn + BW'(1);
                end
                if (sample_stb) sn <= sn + BW'(1);
                rx <= rx_nxt;
            end
        end
    end

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || load) |=> (bitn == '0 && sn == '0 && !drv));
    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (sn == '0));
endmodule

// File: rtl/spi_ctl.sv
// SPI controller top: host register port, role selection, master
// transfer sequencing, slave input conditioning and mode-fault handling.
// Assumes the host does not rewrite the data register mid-transfer
// (such writes are ignored) and that slave inputs are slow versus clk.
module spi_ctl
    import spi_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       xfer_done,
    output logic       mode_fault,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       cs_n_o,
    input  logic       sck_i,
    input  logic       mosi_i,
    input  logic       ss_n_i,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe
);
    localparam int EDGES = 2 * DW;
    localparam int EW    = $clog2(EDGES);

    ctl_t          ctl;
    logic          busy_q, done_q, fault_q;
    logic [DW-1:0] data_q;
    logic [EW-1:0] ek;

    logic wr_ctl, wr_dat, rd_dat, rd_sts;
    logic s_sck, s_ss_n, s_mosi, sck_d;
    logic sck_rise, sck_fall;
    logic fault_hit, start, abort, slave_act, last_edge;
    logic edge_stb, phase;
    logic m_lead, m_trail, s_lead, s_trail;
    logic sh_done, sdo;
    logic [DW-1:0] rx_nxt;

    // Host strobes decoded by address.
    assign wr_ctl = reg_wr && reg_addr == A_CTL;
    assign wr_dat = reg_wr && reg_addr == A_DAT;
    assign rd_dat = reg_rd && reg_addr == A_DAT;
    assign rd_sts = reg_rd && reg_addr == A_STS;

    spi_ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({mosi_i, ss_n_i, sck_i}),
        .q     ({s_mosi, s_ss_n, s_sck})
    );

    // Remember the previous synchronized clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= s_sck;
    end

    assign sck_rise  = s_sck && !sck_d;
    assign sck_fall  = !s_sck && sck_d;
    assign fault_hit = ctl.en && ctl.mst && !s_ss_n;
    assign slave_act = ctl.en && !ctl.mst && !s_ss_n;
    assign start     = wr_dat && ctl.en && ctl.mst && !busy_q && !fault_hit;
    assign abort     = fault_hit || (wr_ctl && !(reg_wdata[6] && reg_wdata[4]));

    spi_ctl_clkgen #(.CW(HALF_W)) i_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_q),
        .half     (half_period(ctl.rate, ctl.dbl)),
        .edge_stb (edge_stb),
        .phase    (phase)
    );

    assign m_lead    = busy_q && edge_stb && !phase;
    assign m_trail   = busy_q && edge_stb && phase;
    assign s_lead    = slave_act && (ctl.cpol ? sck_fall : sck_rise);
    assign s_trail   = slave_act && (ctl.cpol ? sck_rise : sck_fall);
    assign last_edge = m_trail && (ek == EW'(EDGES - 1));

    spi_ctl_shift #(.DW(DW)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!ctl.mst && s_ss_n),
        .load      (wr_dat && !busy_q),
        .load_byte (reg_wdata),
        .lead_stb  (m_lead || s_lead),
        .trail_stb (m_trail || s_trail),
        .cpha      (ctl.cpha),
        .lsb_first (ctl.lsb_first),
        .sdi       (ctl.mst ? miso_i : s_mosi),
        .sdo       (sdo),
        .done      (sh_done),
        .rx_nxt    (rx_nxt)
    );

    // Control register; a mode fault overrides the host's master bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (wr_ctl)    ctl     <= ctl_t'(reg_wdata);
            if (fault_hit) ctl.mst <= 1'b0;
        end
    end

    // Master transfer sequencing: busy flag and edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ek     <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            ek     <= '0;
        end else if (last_edge) begin
            busy_q <= 1'b0;
        end else if (m_lead || m_trail) begin
            ek <= ek + EW'(1);
        end
    end

    // Received byte and sticky flags; setting wins over read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            if (sh_done) begin
                data_q <= rx_nxt;
                done_q <= 1'b1;
            end else if (rd_dat) begin
                done_q <= 1'b0;
            end
            if (fault_hit)   fault_q <= 1'b1;
            else if (rd_sts) fault_q <= 1'b0;
        end
    end

    // Host read mux.
    always_comb begin
        case (reg_addr)
            A_CTL:   reg_rdata = ctl;
            A_DAT:   reg_rdata = data_q;
            A_STS:   reg_rdata = {6'b0, fault_q, done_q};
            default: reg_rdata = '0;
        endcase
    end

    assign sck_o      = busy_q ? (ctl.cpol ^ phase) : ctl.cpol;
    assign cs_n_o     = !busy_q;
    assign mosi_o     = busy_q && sdo;
    assign miso_o     = sdo;
    assign miso_oe    = slave_act;
    assign xfer_done  = done_q;
    assign mode_fault = fault_q;

    // R3
    busy_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> (ctl.en && ctl.mst));
    // R5
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && !edge_stb && !wr_ctl) |=> ($stable(sck_o) || cs_n_o));
    // R8
    fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> (!ctl.mst && fault_q && cs_n_o));
    // R7
    done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_done |=> done_q);
    // R10
    tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ss_n |-> !miso_oe);
endmodule

// File: tb/test_spi_ctl.sv
module test_spi_ctl;
    localparam int CLK_T = 10;
    localparam int SP    = 8;   // slave clock phase length in clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       xfer_done, mode_fault;
    logic       sck_o, mosi_o, cs_n_o;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1, miso_i = 1'b0;
    logic       miso_o, miso_oe;

    int total = 0;
    int bad   = 0;

    spi_ctl i_spi_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_done(xfer_done), .mode_fault(mode_fault),
        .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o),
        .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_i(miso_i),
        .miso_o(miso_o), .miso_oe(miso_oe)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bit on the data line after k clock edges (reference model).
    function automatic logic bitv(input logic [7:0] b, input int k, input logic cpha, input logic lsb);
        int j;
        if (cpha) begin
            if (k == 0) return 1'b0;
            j = (k - 1) / 2;
        end else begin
            j = k / 2;
        end
        if (j > 7) j = 7;
        return lsb ? b[j] : b[7-j];
    endfunction

    function automatic int half_of(input logic [1:0] rate, input logic dbl);
        int h;
        h = (rate == 0) ? 2 : (rate == 1) ? 8 : (rate == 2) ? 32 : 64;
        return dbl ? h / 2 : h;
    endfunction

    // R4 R5 R6 R7: master transfer compared against the model every clock.
    task automatic master_xfer(input logic [1:0] mode, input logic lsb, input logic [1:0] rate,
                               input logic dbl, input logic [7:0] txb, input logic [7:0] sb);
        int h, k, miss;
        logic bz, e_sck, e_mosi;
        logic [7:0] r;
        h = half_of(rate, dbl);
        miss = 0;
        wr(2'd0, {dbl, 1'b1, lsb, 1'b1, mode, rate});
        wr(2'd1, txb);
        for (int n = 0; n <= 16*h + 1; n++) begin
            k = n / h;
            if (k > 16) k = 16;
            bz = (n < 16*h);
            e_sck  = bz ? (mode[1] ^ k[0]) : mode[1];
            e_mosi = bz ? bitv(txb, k, mode[0], lsb) : 1'b0;
            if ((sck_o !== e_sck || cs_n_o !== !bz || mosi_o !== e_mosi) && miss == 0) begin
                miss = 1;
                $display("FAIL R4/R5/R6 pins cycle %0d: actual sck=%b cs=%b mosi=%b expected sck=%b cs=%b mosi=%b",
                         n, sck_o, cs_n_o, mosi_o, e_sck, !bz, e_mosi);
            end
            miso_i = bitv(sb, k, mode[0], lsb);
            @(negedge clk);
        end
        total++;
        if (miss != 0) bad++;
        check(xfer_done === 1'b1, "R7 done flag", xfer_done, 1);
        rd(2'd1, r);
        check(r === sb, "R6 R7 received byte", r, sb);
        rd(2'd2, r);
        check(r[0] === 1'b0, "R7 flag cleared by data read", r[0], 0);
    endtask

    // R9 R10: the bench acts as master toward the slave.
    task automatic slave_xfer(input logic [1:0] mode, input logic lsb, input logic do_wr,
                              input logic [7:0] txb, input logic [7:0] mb, input int nbits);
        logic [7:0] r;
        logic cpol, cpha;
        cpol = mode[1]; cpha = mode[0];
        wr(2'd0, {1'b0, 1'b1, lsb, 1'b0, mode, 2'b11});
        if (do_wr) wr(2'd1, txb);
        sck_i = cpol;
        idle(SP);
        check(miso_oe === 1'b0, "R10 tri-state with select high", miso_oe, 0);
        ss_n_i = 1'b0;
        idle(SP);
        check(miso_oe === 1'b1, "R9 output enabled when selected", miso_oe, 1);
        for (int j = 0; j < nbits; j++) begin
            if (!cpha) begin
                mosi_i = lsb ? mb[j] : mb[7-j];
                idle(SP);
                check(miso_o === (lsb ? txb[j] : txb[7-j]), "R9 R6 slave out bit", miso_o, lsb ? txb[j] : txb[7-j]);
                sck_i = ~cpol; idle(SP);
                sck_i = cpol;  idle(SP);
            end else begin
                sck_i = ~cpol; idle(SP);
                mosi_i = lsb ? mb[j] : mb[7-j];
                idle(SP);
                check(miso_o === (lsb ? txb[j] : txb[7-j]), "R9 R5 slave out bit", miso_o, lsb ? txb[j] : txb[7-j]);
                sck_i = cpol; idle(SP);
            end
        end
        ss_n_i = 1'b1;
        idle(SP);
        check(miso_oe === 1'b0, "R10 tri-state after select rises", miso_oe, 0);
        if (nbits == 8) begin
            rd(2'd2, r);
            check(r[0] === 1'b1, "R9 slave done flag", r[0], 1);
            rd(2'd1, r);
            check(r === mb, "R9 slave received byte", r, mb);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int moved;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n_o === 1'b1 && sck_o === 1'b0 && miso_oe === 1'b0, "R1 pins", {cs_n_o, sck_o, miso_oe}, 3'b100);
        rd(2'd0, r); check(r === 8'h00, "R1 control", r, 0);
        rd(2'd2, r); check(r === 8'h00, "R1 status", r, 0);

        // R2 readback
        wr(2'd0, 8'hA5); rd(2'd0, r); check(r === 8'hA5, "R2 control readback", r, 8'hA5);

        // R5 idle level follows mode bit 3
        wr(2'd0, 8'h58); @(negedge clk); check(sck_o === 1'b1, "R5 idle high", sck_o, 1);
        wr(2'd0, 8'h50); @(negedge clk); check(sck_o === 1'b0, "R5 idle low", sck_o, 0);

        // R3 disabled: no transfer
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h3C);
        moved = 0;
        for (int i = 0; i < 40; i++) begin
            if (cs_n_o !== 1'b1 || sck_o !== 1'b0) moved = 1;
            @(negedge clk);
        end
        check(moved == 0, "R3 no activity while disabled", moved, 0);
        wr(2'd0, 8'h00);
        ss_n_i = 1'b0; idle(6);
        check(miso_oe === 1'b0, "R3 slave output off while disabled", miso_oe, 0);
        ss_n_i = 1'b1; idle(4);

        // Master transfers over modes, orders and rates
        master_xfer(2'd0, 1'b0, 2'd0, 1'b1, 8'hA3, 8'h5E);
        master_xfer(2'd1, 1'b1, 2'd1, 1'b0, 8'h81, 8'hC6);
        master_xfer(2'd2, 1'b0, 2'd0, 1'b0, 8'h6D, 8'h17);
        master_xfer(2'd3, 1'b1, 2'd2, 1'b1, 8'hF0, 8'h29);
        master_xfer(2'd1, 1'b0, 2'd3, 1'b0, 8'h4B, 8'hB2);

        // R8 mode fault mid-transfer
        wr(2'd0, 8'h5B);
        wr(2'd1, 8'hAA);
        idle(20);
        check(cs_n_o === 1'b0, "R8 transfer running before fault", cs_n_o, 0);
        ss_n_i = 1'b0;
        idle(5);
        check(sck_o === 1'b1 && cs_n_o === 1'b1, "R8 pins idle after fault", {sck_o, cs_n_o}, 2'b11);
        check(mode_fault === 1'b1, "R8 fault flag", mode_fault, 1);
        rd(2'd0, r); check(r === 8'h4B, "R8 master bit cleared", r, 8'h4B);
        ss_n_i = 1'b1; idle(4);
        rd(2'd2, r); check(r[1] === 1'b1, "R8 status fault", r[1], 1);
        rd(2'd2, r); check(r[1] === 1'b0, "R8 fault cleared by status read", r[1], 0);

        // R9 slave transfers
        slave_xfer(2'd0, 1'b0, 1'b1, 8'h96, 8'h3A, 8);
        slave_xfer(2'd1, 1'b1, 1'b1, 8'h2C, 8'hE5, 8);
        slave_xfer(2'd3, 1'b0, 1'b1, 8'hB4, 8'h71, 8);
        // R10 partial byte then restart without reloading
        slave_xfer(2'd2, 1'b1, 1'b1, 8'h5A, 8'hFF, 3);
        slave_xfer(2'd2, 1'b1, 1'b0, 8'h5A, 8'h0D, 8);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule